// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block receives a stereo audio stream from an external source that owns the clocks. It accepts a bit clock, a frame clock that tells left from right, and a serial data line. It turns the stream into 24-bit left and right samples. Each finished sample is put out with a one-cycle strobe. When a right sample closes a stereo pair, a separate pair strobe fires as well. The whole block runs on the rising edge of the bit clock, so that clock is also the block's clock.

A 2-bit format input models a three-level strap pin. One bit says the pin is floating, and the other bit gives its logic level when it is driven. Three alignments are supported, and the number of bit clocks in a half-frame may differ from one half-frame to the next:
- **Left-justified:** the word starts at the frame-clock edge.
- **Standard I2S:** the word starts one bit after the frame-clock edge.
- **Right-justified:** the word ends on the bit just before the frame-clock edge.

In the two start-aligned formats, a half-frame too short for a full word gives a sample padded with zeros at the low end. It also sets a sticky flag.

Top module: `aud_ser_rx`

## Requirements
- R1: While `rst` is high and after its release, `left_out` and `right_out` are zero, all strobes are low and `short_flag` is low until a sample is produced.
- R2: The format pin decodes as follows. `fmt_pin[1]`=1 means floating, which selects right-justified whatever `fmt_pin[0]` is. With `fmt_pin[1]`=0, `fmt_pin[0]`=0 selects left-justified and `fmt_pin[0]`=1 selects I2S.
- R3: Left-justified: the MSB is sampled on the first rising edge after a frame-clock change. The next 23 edges carry the rest of the word, MSB first. Bit clocks after the 24th bit have no effect on the sample.
- R4: I2S: the MSB is sampled on the second rising edge after a frame-clock change. The next 23 edges carry the rest of the word, MSB first. Bits beyond the 24th are ignored.
- R5: Right-justified: the sample is the last 24 bits before a frame-clock change, with the LSB on the last edge before the change. Idle bit clocks ahead of the word have no effect.
- R6: Frame clock low means left and high means right; in I2S the channel is the frame-clock level one bit after the edge. A sample's strobe is high for one cycle:
  - in left- and right-justified, in the cycle after the rising edge that sees the frame-clock change ending the sample's half-frame;
  - in I2S, one cycle later.
  - The left and right strobes are never high together.
- R7: `pair_vld` pulses together with `right_vld` when a left sample was put out since the previous right sample.
- R8: In left-justified or I2S, a half-frame with N<24 bit clocks gives the N received bits in the top of the sample and zeros below. It also sets `short_flag`, which stays set until reset.
- R9: The half-frame in progress when the first frame-clock change after reset is seen produces no sample.
- R10: `left_out` and `right_out` hold their values between strobes of their own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrck | input | 1 | Frame clock: low for left, high for right |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_pin | input | 2 | Three-level pin model: bit 1 = floating, bit 0 = driven level |
| left_out | output | 24 | Last left sample |
| right_out | output | 24 | Last right sample |
| left_vld | output | 1 | One-cycle strobe for a new left sample |
| right_vld | output | 1 | One-cycle strobe for a new right sample |
| pair_vld | output | 1 | One-cycle strobe for a completed left/right pair |
| short_flag | output | 1 | Sticky flag for a truncated half-frame |

## Verification
A wrong bit counter or a wrong start point shows up as a shifted sample at the next strobe, which comes within one half-frame. The first corrupted word exposes it. A bad channel register or a bad frame-edge register moves the strobe by a cycle or sends the word to the wrong output, and the bench checks the cycle of every strobe. A wrong right-justified shift register gives wrong low bits on the first word after the bad bit. A broken pair tracker shows up as a missing or extra `pair_vld` in the same cycle as the right strobe.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;

    localparam int unsigned SAMPLE_W = 24;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_I2S = 2'd1,
        FMT_RJ  = 2'd2
    } fmt_e;

    typedef struct packed {
        logic vld;
        logic ch;
        logic shrt;
    } word_ev_t;

    function automatic fmt_e decode_pin(input logic [1:0] pin);
        if (pin[1]) return FMT_RJ;
        return pin[0] ? FMT_I2S : FMT_LJ;
    endfunction

endpackage

// File: rtl/asr_frame_edge.sv
module asr_frame_edge (
    input  logic clk,
    input  logic rst,
    input  logic lrck,
    output logic fedge,
    output logic fedge_d,
    output logic prev_lvl
);
    logic lr_q;
    logic lr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_q    <= 1'b0;
            lr_ok   <= 1'b0;
            fedge_d <= 1'b0;
        end else begin
            lr_q    <= lrck;
            lr_ok   <= 1'b1;
            fedge_d <= fedge;
        end
    end

    assign fedge    = lr_ok & (lrck ^ lr_q);
    assign prev_lvl = lr_q;

endmodule

// File: rtl/asr_rj_capture.sv
module asr_rj_capture
    import aud_ser_rx_pkg::*;
#(
    parameter int unsigned W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdata,
    input  logic         fedge,
    input  logic         prev_lvl,
    output word_ev_t     ev,
    output logic [W-1:0] data
);
    logic [W-1:0] sh;
    logic         armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            armed <= 1'b0;
        end else begin
            sh    <= {sh[W-2:0], sdata};
            armed <= armed | fedge;
        end
    end

    always_comb begin
        ev.vld  = fedge & armed;
        ev.ch   = prev_lvl;
        ev.shrt = 1'b0;
        data    = sh;
    end

endmodule

// File: rtl/asr_ji_capture.sv
module asr_ji_capture
    import aud_ser_rx_pkg::*;
#(
    parameter int unsigned W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdata,
    input  logic         start,
    input  logic         lrck,
    output word_ev_t     ev,
    output logic [W-1:0] data
);
    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [W-1:0]  acc;
    logic [CW-1:0] cnt;
    logic          ch;
    logic          armed;

    function automatic logic [W-1:0] zpad(input logic [W-1:0] v, input logic [CW-1:0] n);
        return v << (W - int'(n));
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            cnt   <= '0;
            ch    <= 1'b0;
            armed <= 1'b0;
        end else if (start) begin
            acc   <= {{(W-1){1'b0}}, sdata};
            cnt   <= CW'(1);
            ch    <= lrck;
            armed <= 1'b1;
        end else if (cnt < FULL) begin
            acc <= {acc[W-2:0], sdata};
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        ev.vld  = start & armed;
        ev.ch   = ch;
        ev.shrt = (cnt < FULL);
        data    = zpad(acc, cnt);
    end

    // R3 / R4: the bit counter never runs past one word
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst) cnt <= FULL);

endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
    import aud_ser_rx_pkg::*;
#(
    parameter int unsigned W = SAMPLE_W
) (
    input  logic         bclk,
    input  logic         rst,
    input  logic         lrck,
    input  logic         sdata,
    input  logic [1:0]   fmt_pin,
    output logic [W-1:0] left_out,
    output logic [W-1:0] right_out,
    output logic         left_vld,
    output logic         right_vld,
    output logic         pair_vld,
    output logic         short_flag
);
    fmt_e         fmt;
    logic         fedge, fedge_d, prev_lvl, ji_start;
    word_ev_t     ji_ev, rj_ev, sel_ev;
    logic [W-1:0] ji_data, rj_data, sel_data;
    logic         have_left;

    assign fmt      = decode_pin(fmt_pin);
    assign ji_start = (fmt == FMT_I2S) ? fedge_d : fedge;

    asr_frame_edge u_edge (
        .clk      (bclk),
        .rst      (rst),
        .lrck     (lrck),
        .fedge    (fedge),
        .fedge_d  (fedge_d),
        .prev_lvl (prev_lvl)
    );

    asr_ji_capture #(.W(W)) u_ji (
        .clk   (bclk),
        .rst   (rst),
        .sdata (sdata),
        .start (ji_start),
        .lrck  (lrck),
        .ev    (ji_ev),
        .data  (ji_data)
    );

    asr_rj_capture #(.W(W)) u_rj (
        .clk      (bclk),
        .rst      (rst),
        .sdata    (sdata),
        .fedge    (fedge),
        .prev_lvl (prev_lvl),
        .ev       (rj_ev),
        .data     (rj_data)
    );

    always_comb begin
        if (fmt == FMT_RJ) begin
            sel_ev   = rj_ev;
            sel_data = rj_data;
        end else begin
            sel_ev   = ji_ev;
            sel_data = ji_data;
        end
    end

    always_ff @(posedge bclk) begin
        if (rst) begin
            left_out   <= '0;
            right_out  <= '0;
            left_vld   <= 1'b0;
            right_vld  <= 1'b0;
            pair_vld   <= 1'b0;
            short_flag <= 1'b0;
            have_left  <= 1'b0;
        end else begin
            left_vld  <= sel_ev.vld & ~sel_ev.ch;
            right_vld <= sel_ev.vld & sel_ev.ch;
            pair_vld  <= sel_ev.vld & sel_ev.ch & have_left;
            if (sel_ev.vld) begin
                if (sel_ev.ch) begin
                    right_out <= sel_data;
                    have_left <= 1'b0;
                end else begin
                    left_out  <= sel_data;
                    have_left <= 1'b1;
                end
                if (sel_ev.shrt) short_flag <= 1'b1;
            end
        end
    end

    // R7: a pair strobe only accompanies a right strobe
    a_r7_pair_with_right: assert property (@(posedge bclk) disable iff (rst) pair_vld |-> right_vld);
    // R6: the two channel strobes never coincide
    a_r6_one_channel: assert property (@(posedge bclk) disable iff (rst) !(left_vld && right_vld));
    // R8: the short-frame flag is sticky
    a_r8_flag_sticky: assert property (@(posedge bclk) disable iff (rst) short_flag |=> short_flag);
    // R6: a strobe follows a frame edge, or its one-bit-delayed copy
    a_r6_strobe_after_edge: assert property (@(posedge bclk) disable iff (rst)
        (left_vld || right_vld) |-> $past(fedge || fedge_d));

endmodule

// File: tb/sim_aud_ser_rx.sv
module sim_aud_ser_rx;
    localparam int CLK_P = 10;

    logic        bclk = 1'b0;
    logic        rst = 1'b1;
    logic        lrck = 1'b1;
    logic        sdata = 1'b0;
    logic [1:0]  fmt_pin = 2'b00;
    logic [23:0] left_out, right_out;
    logic        left_vld, right_vld, pair_vld, short_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int          got_n = 0;
    logic        got_ch  [64];
    logic [23:0] got_dat [64];
    int          got_cyc [64];
    int          pair_n = 0;
    int          edge_n = 0;
    int          edge_log [64];

    aud_ser_rx u0 (
        .bclk(bclk), .rst(rst), .lrck(lrck), .sdata(sdata), .fmt_pin(fmt_pin),
        .left_out(left_out), .right_out(right_out), .left_vld(left_vld),
        .right_vld(right_vld), .pair_vld(pair_vld), .short_flag(short_flag)
    );

    always #(CLK_P/2) bclk = ~bclk;

    always @(posedge bclk) cyc <= cyc + 1;

    always @(negedge bclk) begin
        if (left_vld && got_n < 64) begin
            got_ch[got_n] = 1'b0; got_dat[got_n] = left_out; got_cyc[got_n] = cyc; got_n++;
        end
        if (right_vld && got_n < 64) begin
            got_ch[got_n] = 1'b1; got_dat[got_n] = right_out; got_cyc[got_n] = cyc; got_n++;
        end
        if (pair_vld) pair_n++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // fmt: 0 LJ, 1 I2S, 2 RJ
    function automatic logic bit_at(input int fmt, input logic [23:0] w, input int n, input int i);
        if (fmt == 0) return (i < 24) ? w[23-i] : i[0];
        if (fmt == 1) return (i >= 1 && i <= 24) ? w[24-i] : ~i[0];
        return (i >= n - 24) ? w[23-(i-(n-24))] : 1'b1;
    endfunction

    task automatic drive_half(input logic lvl, input logic [23:0] w, input int n, input int fmt);
        for (int i = 0; i < n; i++) begin
            @(negedge bclk);
            if (i == 0) begin
                lrck = lvl;
                if (edge_n < 64) begin edge_log[edge_n] = cyc; edge_n++; end
            end
            sdata = bit_at(fmt, w, n, i);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        fmt_pin = m;
        lrck = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge bclk);
        rst = 1'b0;
        repeat (2) @(negedge bclk);
    endtask

    task automatic chk_word(input int idx, input int eidx, input int lat, input logic ch,
                            input logic [23:0] w, input string req);
        chk(got_ch[idx] == ch, req, got_ch[idx], ch);
        chk(got_dat[idx] == w, req, got_dat[idx], w);
        chk(got_cyc[idx] == edge_log[eidx] + lat, "R6", got_cyc[idx], edge_log[eidx] + lat);
    endtask

    task automatic t_reset;
        fmt_pin = 2'b00; rst = 1'b1; lrck = 1'b1;
        repeat (3) @(negedge bclk);
        chk(left_out == 0 && right_out == 0, "R1", {left_out, right_out}, 0);
        chk(!left_vld && !right_vld && !pair_vld, "R1", {left_vld, right_vld, pair_vld}, 0);
        chk(!short_flag, "R1", short_flag, 0);
        rst = 1'b0;
        repeat (2) @(negedge bclk);
        chk(left_out == 0 && !left_vld && !short_flag, "R1", {left_out, left_vld, short_flag}, 0);
    endtask

    task automatic t_lj;
        int gb, eb, pb;
        do_reset(2'b00);
        gb = got_n; eb = edge_n; pb = pair_n;
        drive_half(0, 24'hA5C3E1, 32, 0);
        drive_half(1, 24'h123456, 30, 0);
        drive_half(0, 24'hFEDCBA, 24, 0);
        drive_half(1, 24'h000000, 32, 0);
        chk(got_n - gb == 3, "R9", got_n - gb, 3);
        chk_word(gb,     eb + 1, 1, 0, 24'hA5C3E1, "R3");
        chk_word(gb + 1, eb + 2, 1, 1, 24'h123456, "R3");
        chk_word(gb + 2, eb + 3, 1, 0, 24'hFEDCBA, "R3");
        chk(pair_n - pb == 1, "R7", pair_n - pb, 1);
        chk(left_out == 24'hFEDCBA && right_out == 24'h123456, "R10", {left_out, right_out},
            {24'hFEDCBA, 24'h123456});
        chk(!short_flag, "R8", short_flag, 0);
    endtask

    task automatic t_i2s;
        int gb, eb, pb;
        do_reset(2'b01);
        gb = got_n; eb = edge_n; pb = pair_n;
        drive_half(0, 24'h7E0F81, 32, 1);
        drive_half(1, 24'h800001, 25, 1);
        drive_half(0, 24'h3C3C3C, 40, 1);
        drive_half(1, 24'h000000, 32, 1);
        chk(got_n - gb == 3, "R4", got_n - gb, 3);
        chk_word(gb,     eb + 1, 2, 0, 24'h7E0F81, "R4");
        chk_word(gb + 1, eb + 2, 2, 1, 24'h800001, "R4");
        chk_word(gb + 2, eb + 3, 2, 0, 24'h3C3C3C, "R4");
        chk(pair_n - pb == 1, "R7", pair_n - pb, 1);
    endtask

    task automatic t_rj(input logic [1:0] m);
        int gb, eb, pb;
        do_reset(m);
        gb = got_n; eb = edge_n; pb = pair_n;
        drive_half(0, 24'h5AA5F0, 32, 2);
        drive_half(1, 24'h0F1E2D, 24, 2);
        drive_half(0, 24'hC0FFEE, 40, 2);
        drive_half(1, 24'h000000, 32, 2);
        chk(got_n - gb == 3, "R2", got_n - gb, 3);
        chk_word(gb,     eb + 1, 1, 0, 24'h5AA5F0, "R5");
        chk_word(gb + 1, eb + 2, 1, 1, 24'h0F1E2D, "R5");
        chk_word(gb + 2, eb + 3, 1, 0, 24'hC0FFEE, "R5");
        chk(pair_n - pb == 1, "R7", pair_n - pb, 1);
    endtask

    task automatic t_short;
        int gb, eb;
        do_reset(2'b00);
        gb = got_n; eb = edge_n;
        drive_half(0, 24'hABCDEF, 16, 0);
        drive_half(1, 24'h654321, 32, 0);
        drive_half(0, 24'h000000, 32, 0);
        chk(got_n - gb == 2, "R8", got_n - gb, 2);
        chk_word(gb,     eb + 1, 1, 0, 24'hABCD00, "R8");
        chk_word(gb + 1, eb + 2, 1, 1, 24'h654321, "R8");
        chk(short_flag, "R8", short_flag, 1);
    endtask

    always @(posedge bclk) begin
        if (cyc > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 50000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lj();
        t_i2s();
        t_rj(2'b10);
        t_rj(2'b11);
        t_short();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule